// File: doc/BRIEF.md
# Performance Monitor Register Bank

This block holds the system registers of a minimal performance monitor that has no event counters. A processor core reaches it through a coprocessor-style access port. Each request carries a primary index, a secondary index, an opcode index, a read/write flag and the current privilege level (user or privileged). The block answers each request one clock later with registered read data or with an undefined-access fault. The core turns that fault into an undefined-instruction trap.

The register group contains the following. A control word whose implementor byte comes from an ID input. A count-enable word and an interrupt-enable word, each reached through a set address and a clear address. A write-one-to-clear overflow status word. An event-type byte. A user-enable bit. Four placeholder registers that read as zero. The user-enable bit decides whether user code may reach the counter registers. The interrupt-enable pair is always closed to user code.

Top module: `pmu_regbank`

## Requirements
- R1: A synchronous active-high reset loads the control word with bits 31:24 copied from `id_value` and all other bits zero. The count-enable, interrupt-enable, overflow, event-type and user-enable state reset to zero.
- R2: A write to control (secondary 12, opcode 0) changes only bits 0, 3, 4 and 5 (mask 0x39). Every other bit keeps its value.
- R3: Count-enable set (12/1) and clear (12/2) share one word, and only bit 31 can change. Set ORs in the masked data, clear removes the masked data, and both addresses read the shared word.
- R4: Interrupt-enable set (14/1) and clear (14/2) share one word with the same bit-31-only set/clear behaviour.
- R5: A write to overflow status (12/3) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R6: Event type (13/1) stores only the low 8 bits of the written data. The upper bits read as zero.
- R7: User-enable (14/0) stores only bit 0. Privileged code may read and write it. User code may read it, and a user write faults.
- R8: Any user-mode access to interrupt-enable set or clear faults, whatever the user-enable bit holds.
- R9: Control, count-enable, overflow, software increment, select, cycle count, event type and event count fault in user mode when user-enable is 0. They are accessible from user mode when it is 1.
- R10: Software increment (12/4), select (12/5), cycle count (13/0) and event count (13/2) read as zero and ignore writes.
- R11: An access faults if the primary index is not 9 or the secondary/opcode pair is not listed. A faulting access changes no stored state and returns zero data.
- R12: `rsp_valid`, `rsp_fault` and `rsp_rdata` are registered and relate to the request of the previous clock. Without a request, the valid and fault outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = user privilege, 0 = privileged |
| req_crn | input | 4 | Primary index |
| req_crm | input | 4 | Secondary index |
| req_op2 | input | 3 | Opcode index |
| req_wdata | input | 32 | Write data |
| id_value | input | 32 | Identification word; bits 31:24 seed the control word |
| rsp_valid | output | 1 | Response for previous cycle's request |
| rsp_fault | output | 1 | Undefined-access fault for that request |
| rsp_rdata | output | 32 | Read data, zero on writes and faults |

## Verification
The bench targets these corner cases:
- A control write with all ones. Leaking non-writable bits would alter the implementor byte or the reserved zeros.
- A clear write with bit 31 low. It must not disturb the enable word. A swapped set/clear polarity shows up as a wrong read through the opposite address.
- User reads and writes of user-enable, and user accesses to the interrupt pair with user-enable at 1. A privilege check that is too loose or too strict flips the fault output.
- Faulting writes, including writes to unlisted addresses and foreign primary indices. A later privileged read shows any state they corrupted.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;
  localparam int OP_W   = 3;
  localparam logic [IDX_W-1:0] PRIMARY_IDX = 4'd9;

  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h0000_0039;
  localparam logic [DATA_W-1:0] IMPL_MASK  = 32'hFF00_0000;
  localparam logic [DATA_W-1:0] PAIR_MASK  = 32'h8000_0000;
  localparam logic [DATA_W-1:0] EVT_MASK   = 32'h0000_00FF;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_CNT_SET, RG_CNT_CLR, RG_OVS, RG_SWINC, RG_SEL,
    RG_CYC, RG_EVT, RG_EVCNT, RG_UEN, RG_INT_SET, RG_INT_CLR
  } pmu_reg_e;

  function automatic pmu_reg_e pmu_decode(input logic [IDX_W-1:0] crn,
                                          input logic [IDX_W-1:0] crm,
                                          input logic [OP_W-1:0]  op2);
    pmu_reg_e r = RG_NONE;
    if (crn == PRIMARY_IDX) begin
      unique case (crm)
        4'd12: case (op2)
          3'd0: r = RG_CTRL;    3'd1: r = RG_CNT_SET; 3'd2: r = RG_CNT_CLR;
          3'd3: r = RG_OVS;     3'd4: r = RG_SWINC;   3'd5: r = RG_SEL;
          default: r = RG_NONE;
        endcase
        4'd13: case (op2)
          3'd0: r = RG_CYC; 3'd1: r = RG_EVT; 3'd2: r = RG_EVCNT;
          default: r = RG_NONE;
        endcase
        4'd14: case (op2)
          3'd0: r = RG_UEN; 3'd1: r = RG_INT_SET; 3'd2: r = RG_INT_CLR;
          default: r = RG_NONE;
        endcase
        default: r = RG_NONE;
      endcase
    end
    return r;
  endfunction

  function automatic logic pmu_denied(input pmu_reg_e r, input logic user,
                                      input logic write, input logic uen);
    logic d;
    case (r)
      RG_NONE:                d = 1'b1;
      RG_INT_SET, RG_INT_CLR: d = user;
      RG_UEN:                 d = user & write;
      default:                d = user & ~uen;
    endcase
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_merge(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] wr_v);
    return (old_v & ~CTRL_WMASK) | (wr_v & CTRL_WMASK);
  endfunction

  function automatic logic [DATA_W-1:0] pair_update(input logic [DATA_W-1:0] old_v,
                                                    input logic [DATA_W-1:0] wr_v,
                                                    input logic is_set);
    return is_set ? (old_v | (wr_v & PAIR_MASK)) : (old_v & ~(wr_v & PAIR_MASK));
  endfunction
endpackage

// File: rtl/pmu_access_decode.sv
module pmu_access_decode
  import pmu_pkg::*;
(
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [IDX_W-1:0]  req_crn,
  input  logic [IDX_W-1:0]  req_crm,
  input  logic [OP_W-1:0]   req_op2,
  input  logic              uen,
  output pmu_reg_e          sel_reg,
  output logic              acc_fault,
  output logic              wr_fire
);
  logic denied;

  always_comb begin
    sel_reg   = pmu_decode(req_crn, req_crm, req_op2);
    denied    = pmu_denied(sel_reg, req_user, req_write, uen);
    acc_fault = req_valid & denied;
    wr_fire   = req_valid & req_write & ~denied;
  end
endmodule

// File: rtl/pmu_reg_store.sv
module pmu_reg_store
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  pmu_reg_e          sel_reg,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] id_value,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] cnten_q,
  output logic [DATA_W-1:0] inten_q,
  output logic              uen_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NPAIR = 2;

  logic [NPAIR-1:0]             set_hit, clr_hit;
  logic [NPAIR-1:0][DATA_W-1:0] pair_q;
  logic [DATA_W-1:0]            ovs_q, evt_q;

  assign set_hit[0] = wr_fire & (sel_reg == RG_CNT_SET);
  assign clr_hit[0] = wr_fire & (sel_reg == RG_CNT_CLR);
  assign set_hit[1] = wr_fire & (sel_reg == RG_INT_SET);
  assign clr_hit[1] = wr_fire & (sel_reg == RG_INT_CLR);

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst)                          pair_q[g] <= '0;
      else if (set_hit[g] | clr_hit[g]) pair_q[g] <= pair_update(pair_q[g], wdata, set_hit[g]);
    end
  end

  assign cnten_q = pair_q[0];
  assign inten_q = pair_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= id_value & IMPL_MASK;
      ovs_q  <= '0;
      evt_q  <= '0;
      uen_q  <= 1'b0;
    end else if (wr_fire) begin
      case (sel_reg)
        RG_CTRL: ctrl_q <= ctrl_merge(ctrl_q, wdata);
        RG_OVS:  ovs_q  <= ovs_q & ~wdata;
        RG_EVT:  evt_q  <= wdata & EVT_MASK;
        RG_UEN:  uen_q  <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel_reg)
      RG_CTRL:                rd_data = ctrl_q;
      RG_CNT_SET, RG_CNT_CLR: rd_data = cnten_q;
      RG_INT_SET, RG_INT_CLR: rd_data = inten_q;
      RG_OVS:                 rd_data = ovs_q;
      RG_EVT:                 rd_data = evt_q;
      RG_UEN:                 rd_data = {{(DATA_W-1){1'b0}}, uen_q};
      default:                rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pmu_regbank.sv
module pmu_regbank
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [IDX_W-1:0]  req_crn,
  input  logic [IDX_W-1:0]  req_crm,
  input  logic [OP_W-1:0]   req_op2,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] id_value,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [DATA_W-1:0] rsp_rdata
);
  pmu_reg_e          sel_reg;
  logic              acc_fault, wr_fire, uen_q;
  logic [DATA_W-1:0] ctrl_q, cnten_q, inten_q, rd_data;

  pmu_access_decode u_dec (
    .req_valid (req_valid), .req_write (req_write), .req_user (req_user),
    .req_crn   (req_crn),   .req_crm   (req_crm),   .req_op2  (req_op2),
    .uen       (uen_q),     .sel_reg   (sel_reg),   .acc_fault(acc_fault),
    .wr_fire   (wr_fire)
  );

  pmu_reg_store u_store (
    .clk     (clk),     .rst      (rst),      .wr_fire (wr_fire),
    .sel_reg (sel_reg), .wdata    (req_wdata), .id_value(id_value),
    .ctrl_q  (ctrl_q),  .cnten_q  (cnten_q),  .inten_q (inten_q),
    .uen_q   (uen_q),   .rd_data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= acc_fault;
      rsp_rdata <= (req_valid & ~req_write & ~acc_fault) ? rd_data : '0;
    end
  end
endmodule

// File: rtl/pmu_regbank_chk.sv
module pmu_regbank_chk
  import pmu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_user,
  input logic [IDX_W-1:0]  req_crn,
  input logic [IDX_W-1:0]  req_crm,
  input logic [OP_W-1:0]   req_op2,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] cnten_q,
  input logic [DATA_W-1:0] inten_q,
  input logic              acc_fault
);
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);                                              // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_fault));                            // R12
  AST_CTRL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[23:6] == '0) && (ctrl_q[2:1] == '0));                          // R2
  AST_CNTEN_ONLY_TOP: assert property (@(posedge clk) disable iff (rst)
    cnten_q[30:0] == '0);                                                  // R3
  AST_INTEN_ONLY_TOP: assert property (@(posedge clk) disable iff (rst)
    inten_q[30:0] == '0);                                                  // R4
  AST_UEN_USER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_user && req_write && req_crn == 4'd9 && req_crm == 4'd14
     && req_op2 == 3'd0) |=> rsp_fault);                                   // R7
  AST_INTEN_USER: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_user && req_crn == 4'd9 && req_crm == 4'd14
     && (req_op2 == 3'd1 || req_op2 == 3'd2)) |=> rsp_fault);              // R8
  AST_RAZ_READ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_crn == 4'd9 && req_crm == 4'd12
     && (req_op2 == 3'd4 || req_op2 == 3'd5)) |=> rsp_rdata == '0);        // R10
  AST_FOREIGN_FAULT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_crn != 4'd9 || req_crm == 4'd15)) |=> rsp_fault);   // R11
  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_rdata == '0);                                        // R11
  AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    acc_fault |=> ($stable(ctrl_q) && $stable(cnten_q) && $stable(inten_q))); // R11
endmodule

bind pmu_regbank pmu_regbank_chk u_chk (
  .clk (clk), .rst (rst), .req_valid (req_valid), .req_write (req_write),
  .req_user (req_user), .req_crn (req_crn), .req_crm (req_crm), .req_op2 (req_op2),
  .rsp_valid (rsp_valid), .rsp_fault (rsp_fault), .rsp_rdata (rsp_rdata),
  .ctrl_q (ctrl_q), .cnten_q (cnten_q), .inten_q (inten_q), .acc_fault (acc_fault)
);

// File: tb/test_pmu_regbank.sv
module test_pmu_regbank;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID_VAL = 32'hA512_3456;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 0, req_write = 0, req_user = 0;
  logic [3:0]  req_crn = 0, req_crm = 0;
  logic [2:0]  req_op2 = 0;
  logic [31:0] req_wdata = 0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] m_ctrl, m_cnt, m_int, m_ovs, m_evt;
  logic        m_uen;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmu_regbank i_pmu_regbank (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_write (req_write),
    .req_user (req_user), .req_crn (req_crn), .req_crm (req_crm), .req_op2 (req_op2),
    .req_wdata (req_wdata), .id_value (ID_VAL), .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault), .rsp_rdata (rsp_rdata)
  );

  // Address code: crm*8 + op2, only valid with primary index 9
  function automatic int addr_code(input logic [3:0] crn, input logic [3:0] crm,
                                   input logic [2:0] op2);
    if (crn != 4'd9) return -1;
    if (crm == 12 && op2 <= 5) return 96 + op2;
    if ((crm == 13 || crm == 14) && op2 <= 2) return crm * 8 + op2;
    return -1;
  endfunction

  function automatic bit exp_fault(input bit user, input bit wr, input int a);
    if (a < 0) return 1;
    if (a == 113 || a == 114) return user;   // interrupt pair
    if (a == 112) return user && wr;         // user-enable
    return user && !m_uen;
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    case (a)
      96: return m_ctrl;
      97, 98: return m_cnt;
      99: return m_ovs;
      105: return m_evt;
      112: return {31'd0, m_uen};
      113, 114: return m_int;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    case (a)
      96:  m_ctrl = {m_ctrl[31:6], d[5:3], m_ctrl[2:1], d[0]};
      97:  m_cnt[31] = m_cnt[31] | d[31];
      98:  m_cnt[31] = m_cnt[31] & ~d[31];
      99:  m_ovs = m_ovs & ~d;
      105: m_evt = {24'd0, d[7:0]};
      112: m_uen = d[0];
      113: m_int[31] = m_int[31] | d[31];
      114: m_int[31] = m_int[31] & ~d[31];
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with the response checked
  task automatic access(input string tag, input bit wr, input bit user,
                        input logic [3:0] crn, input logic [3:0] crm,
                        input logic [2:0] op2, input logic [31:0] d);
    int a;
    bit ef;
    logic [31:0] er;
    a  = addr_code(crn, crm, op2);
    ef = exp_fault(user, wr, a);
    er = (!wr && !ef) ? exp_read(a) : 32'd0;
    req_valid = 1; req_write = wr; req_user = user;
    req_crn = crn; req_crm = crm; req_op2 = op2; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    if (wr && !ef) model_write(a, d);
    check({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    check({tag, " fault"}, {31'd0, rsp_fault}, {31'd0, ef});
    check({tag, " data"}, rsp_rdata, er);
  endtask

  task automatic rd(input string tag, input bit user, input logic [3:0] crm,
                    input logic [2:0] op2);
    access(tag, 0, user, 4'd9, crm, op2, 32'd0);
  endtask

  task automatic wrr(input string tag, input bit user, input logic [3:0] crm,
                     input logic [2:0] op2, input logic [31:0] d);
    access(tag, 1, user, 4'd9, crm, op2, d);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_ctrl = ID_VAL & 32'hFF00_0000; m_cnt = 0; m_int = 0; m_ovs = 0; m_evt = 0; m_uen = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12: idle outputs
    check("R12 idle valid", {31'd0, rsp_valid}, 32'd0);
    check("R12 idle fault", {31'd0, rsp_fault}, 32'd0);
    // R1: reset values
    rd("R1 ctrl", 0, 12, 0);
    check("R1 ctrl literal", rsp_rdata, 32'hA500_0000);
    rd("R1 cnten", 0, 12, 1);
    rd("R1 ovs", 0, 12, 3);
    rd("R1 evt", 0, 13, 1);
    rd("R1 uen", 0, 14, 0);
    rd("R1 inten", 0, 14, 2);
    // R2
    wrr("R2 ctrl all ones", 0, 12, 0, 32'hFFFF_FFFF);
    rd("R2 ctrl", 0, 12, 0);
    check("R2 ctrl literal", rsp_rdata, 32'hA500_0039);
    wrr("R2 ctrl zeros", 0, 12, 0, 32'h0);
    rd("R2 ctrl back", 0, 12, 0);
    // R3
    wrr("R3 set", 0, 12, 1, 32'hFFFF_FFFF);
    rd("R3 via clr addr", 0, 12, 2);
    check("R3 literal", rsp_rdata, 32'h8000_0000);
    wrr("R3 clr low bits", 0, 12, 2, 32'h7FFF_FFFF);
    rd("R3 still set", 0, 12, 1);
    wrr("R3 clr top", 0, 12, 2, 32'h8000_0000);
    rd("R3 cleared", 0, 12, 1);
    // R4
    wrr("R4 set", 0, 14, 1, 32'h8000_0001);
    rd("R4 via clr addr", 0, 14, 2);
    check("R4 literal", rsp_rdata, 32'h8000_0000);
    wrr("R4 clr", 0, 14, 2, 32'hFFFF_FFFF);
    rd("R4 cleared", 0, 14, 1);
    // R5
    wrr("R5 w1c", 0, 12, 3, 32'hFFFF_FFFF);
    rd("R5 ovs", 0, 12, 3);
    // R6
    wrr("R6 evt", 0, 13, 1, 32'hDEAD_BE5A);
    rd("R6 evt", 0, 13, 1);
    check("R6 literal", rsp_rdata, 32'h0000_005A);
    // R9 with uen=0
    rd("R9 user ctrl closed", 1, 12, 0);
    wrr("R9 user evt closed", 1, 13, 1, 32'h11);
    rd("R9 evt unchanged", 0, 13, 1);
    // R7
    rd("R7 user read uen", 1, 14, 0);
    wrr("R7 user write uen", 1, 14, 0, 32'h1);
    rd("R7 uen still 0", 0, 14, 0);
    wrr("R7 priv write uen", 0, 14, 0, 32'h3);
    rd("R7 uen bit0", 0, 14, 0);
    check("R7 literal", rsp_rdata, 32'h1);
    // R9 with uen=1
    rd("R9 user ctrl open", 1, 12, 0);
    wrr("R9 user cnt set", 1, 12, 1, 32'h8000_0000);
    rd("R9 user cnt read", 1, 12, 1);
    // R8
    wrr("R8 user int set", 1, 14, 1, 32'h8000_0000);
    rd("R8 user int read", 1, 14, 2);
    rd("R8 int unchanged", 0, 14, 1);
    // R10
    for (int k = 0; k < 4; k++) begin
      logic [3:0] cm = (k < 2) ? 4'd12 : 4'd13;
      logic [2:0] op = (k == 0) ? 3'd4 : (k == 1) ? 3'd5 : (k == 2) ? 3'd0 : 3'd2;
      wrr("R10 write", 0, cm, op, 32'hFFFF_FFFF);
      rd("R10 raz", 0, cm, op);
    end
    // R11
    access("R11 foreign crn", 1, 0, 4'd8, 12, 0, 32'hFFFF_FFFF);
    wrr("R11 unlisted 12/6", 0, 12, 6, 32'hFFFF_FFFF);
    rd("R11 unlisted 15/0", 0, 15, 0);
    wrr("R11 uen off", 0, 14, 0, 32'h0);
    wrr("R11 user ctrl fault", 1, 12, 0, 32'hFFFF_FFFF);
    rd("R11 ctrl unchanged", 0, 12, 0);
    // Random mix
    for (int n = 0; n < 1500; n++) begin
      bit wr = $urandom_range(0, 1);
      bit us = ($urandom_range(0, 3) == 0);
      logic [3:0] cn = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'd9;
      logic [3:0] cm = 4'($urandom_range(11, 15));
      logic [2:0] op = 3'($urandom_range(0, 7));
      logic [31:0] d = $urandom();
      access("R9 random", wr, us, cn, cm, op, d);
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        check("R12 gap valid", {31'd0, rsp_valid}, 32'd0);
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule